// File: doc/BRIEF.md
# Serial FPGA Configuration Master

This block sits on a master board and lets software load bitstreams into slave-serial FPGAs spread over several boards that share one set of wires. Software first writes a selection register that names a target board and a target device position (or all of either). It then streams the configuration by repeatedly writing a data/clock register. Each write carries one serial bit for every device position in parallel, plus the level of the shared configuration clock. A clock pulse is two writes: the clock bit low, then the clock bit high. The slaves take data on the rising edge.

The block decodes the selection into one-hot board and device enables and masks the data lanes of unselected devices. It emits a single-cycle reset strobe when the reset code is selected, and it counts the clock pulses sent since the last selection. It brings the shared open-drain INIT and DONE lines in through a synchronizer. A sticky abort flag records a frame error, which a slave signals by pulling INIT low while a load is under way. All registers and the status can be read back.

Top module: `cfg_serial_master`

## Requirements
- R1: While reset is asserted and before any write, the clock line, all data lanes, all board and device enables, the reset strobe and the pulse count are 0, and the status readback is 0.
- R2: Selection bits 3..0 form the board field. Value n in 1..9 sets only boardSel bit n-1, value 15 sets all nine bits, and value 0 sets none. The enables reflect the new selection from the cycle after the write.
- R3: Selection bits 7..4 form the device field. Value n in 1..7 sets only fpgaSel bit n-1, value 15 sets all seven bits, and values 0 and 14 set none.
- R4: A device field of 8..13 or a board field of 10..14 is invalid. Both enable vectors are then all zero, no reset strobe is issued, and status bit 3 reads 1 until the next valid selection write.
- R5: A selection write whose device field is 14 and whose board field is 1..9 or 15 raises fpgaResetStrobe for exactly one cycle, the cycle after the write. boardSel then shows the target board or boards. With a board field of 0 no strobe is issued.
- R6: Bit 7 of the data/clock register drives cfgClk directly. Data lane i carries bit i of that register ANDed with fpgaSel bit i.
- R7: pulseCount increments by one for every data/clock write that takes bit 7 from 0 to 1. Other data/clock writes leave it unchanged. It saturates at its maximum and is cleared by any selection write.
- R8: INIT and DONE pass through two flip-flop stages. A change on the pins appears in status bits 0 (INIT) and 1 (DONE) two clock edges later.
- R9: The abort flag (status bit 2) sets when the synchronized INIT is low while pulseCount is nonzero. It then stays set whatever INIT does, until a selection write clears it. A low INIT with a zero count does not set it.
- R10: Read address 0 returns the selection register, 1 the data/clock register, 2 the status byte {4'b0, invalid, abort, DONE, INIT}, and 3 returns zero. Write address 0 is the selection register and 1 is the data/clock register. Writes to 2 and 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write enable |
| wrAddr | input | 2 | Register write address |
| wrData | input | 8 | Register write data |
| rdAddr | input | 2 | Register read address |
| rdData | output | 8 | Combinational read data |
| cfgClk | output | 1 | Shared configuration clock |
| cfgData | output | 7 | Serial data lane per device position |
| boardSel | output | 9 | One enable per board |
| fpgaSel | output | 7 | One enable per device position |
| fpgaResetStrobe | output | 1 | Single-cycle reset for the devices on the selected board |
| initIn | input | 1 | Shared INIT line, low on frame error |
| doneIn | input | 1 | Shared DONE line, high when loading is complete |
| pulseCount | output | COUNT_W | Clock pulses since the last selection write |

## Verification
The hardest state to reach is an abort that must be told apart from a harmless INIT low. INIT legitimately sits low before any clock has been sent, so the bench first holds INIT low with a zero pulse count and shows that no abort appears. It then sends one clock pulse and drops INIT again, sampling status after one, two and three edges to pin down the synchronizer depth and the flag's latency. Next it releases INIT to show the flag stays set, and finally rewrites the selection to clear it. Saturation of the pulse counter is reached by building the bench with a four-bit counter, and all 256 selection codes are swept against an arithmetic model.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int REG_W   = 8;
  localparam int FIELD_W = 4;
  localparam logic [FIELD_W-1:0] CODE_NONE  = 4'h0;
  localparam logic [FIELD_W-1:0] CODE_RESET = 4'hE;
  localparam logic [FIELD_W-1:0] CODE_ALL   = 4'hF;
  localparam logic [1:0] ADDR_SEL    = 2'd0;
  localparam logic [1:0] ADDR_DC     = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;

  typedef struct packed {
    logic selWr;
    logic dcWr;
    logic clkRise;
    logic resetReq;
    logic selInvalid;
  } cfgStrobe_t;
endpackage

// File: rtl/cfg_ctrl.sv
module cfg_ctrl
  import cfg_pkg::*;
#(
  parameter int NUM_BOARDS = 9,
  parameter int NUM_FPGAS  = 7
) (
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic             clkLevel,
  output cfgStrobe_t       strobes
);
  localparam logic [FIELD_W-1:0] BOARD_MAX = FIELD_W'(NUM_BOARDS);
  localparam logic [FIELD_W-1:0] FPGA_MAX  = FIELD_W'(NUM_FPGAS);

  logic [FIELD_W-1:0] newBoard;
  logic [FIELD_W-1:0] newFpga;
  logic boardBad, fpgaBad, boardTargeted;

  assign newBoard = wrData[FIELD_W-1:0];
  assign newFpga  = wrData[REG_W-1:FIELD_W];

  always_comb begin
    boardBad      = (newBoard > BOARD_MAX) && (newBoard != CODE_ALL);
    fpgaBad       = (newFpga > FPGA_MAX) && (newFpga < CODE_RESET);
    boardTargeted = (newBoard != CODE_NONE) && !boardBad;

    strobes            = '0;
    strobes.selWr      = wrEn && (wrAddr == ADDR_SEL);
    strobes.dcWr       = wrEn && (wrAddr == ADDR_DC);
    strobes.clkRise    = strobes.dcWr && !clkLevel && wrData[REG_W-1];
    strobes.selInvalid = strobes.selWr && (boardBad || fpgaBad);
    strobes.resetReq   = strobes.selWr && (newFpga == CODE_RESET) && boardTargeted;
  end
endmodule

// File: rtl/cfg_datapath.sv
module cfg_datapath
  import cfg_pkg::*;
#(
  parameter int NUM_BOARDS  = 9,
  parameter int NUM_FPGAS   = 7,
  parameter int COUNT_W     = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  cfgStrobe_t            strobes,
  input  logic [REG_W-1:0]      wrData,
  input  logic [1:0]            rdAddr,
  output logic [REG_W-1:0]      rdData,
  output logic                  clkLevel,
  output logic [NUM_FPGAS-1:0]  cfgData,
  output logic [NUM_BOARDS-1:0] boardSel,
  output logic [NUM_FPGAS-1:0]  fpgaSel,
  output logic                  resetStrobe,
  input  logic                  initIn,
  input  logic                  doneIn,
  output logic [COUNT_W-1:0]    pulseCount
);
  localparam logic [COUNT_W-1:0] COUNT_MAX = '1;

  logic [REG_W-1:0] selReg;
  logic [REG_W-1:0] dcReg;
  logic invalidReg, abortReg;
  logic [SYNC_STAGES-1:0] initPipe, donePipe;
  logic initSync, doneSync;
  logic [FIELD_W-1:0] boardField, fpgaField;

  assign boardField = selReg[FIELD_W-1:0];
  assign fpgaField  = selReg[REG_W-1:FIELD_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selReg      <= '0;
      dcReg       <= '0;
      invalidReg  <= 1'b0;
      resetStrobe <= 1'b0;
    end else begin
      resetStrobe <= strobes.resetReq;
      if (strobes.selWr) begin
        selReg     <= wrData;
        invalidReg <= strobes.selInvalid;
      end
      if (strobes.dcWr) dcReg <= wrData;
    end
  end

  // Select fan-out
  for (genvar b = 0; b < NUM_BOARDS; b++) begin : g_board
    assign boardSel[b] = !invalidReg &&
      ((boardField == FIELD_W'(b + 1)) || (boardField == CODE_ALL));
  end
  for (genvar f = 0; f < NUM_FPGAS; f++) begin : g_fpga
    assign fpgaSel[f] = !invalidReg &&
      ((fpgaField == FIELD_W'(f + 1)) || (fpgaField == CODE_ALL));
    assign cfgData[f] = dcReg[f] & fpgaSel[f];
  end

  assign clkLevel = dcReg[REG_W-1];

  // Pulse counter
  always_ff @(posedge clk) begin
    if (!rst_n) pulseCount <= '0;
    else if (strobes.selWr) pulseCount <= '0;
    else if (strobes.clkRise && (pulseCount != COUNT_MAX)) pulseCount <= pulseCount + 1'b1;
  end

  // INIT / DONE synchronizers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      initPipe <= '0;
      donePipe <= '0;
    end else begin
      initPipe <= {initPipe[SYNC_STAGES-2:0], initIn};
      donePipe <= {donePipe[SYNC_STAGES-2:0], doneIn};
    end
  end
  assign initSync = initPipe[SYNC_STAGES-1];
  assign doneSync = donePipe[SYNC_STAGES-1];

  // Sticky abort
  always_ff @(posedge clk) begin
    if (!rst_n) abortReg <= 1'b0;
    else if (strobes.selWr) abortReg <= 1'b0;
    else if (!initSync && (pulseCount != '0)) abortReg <= 1'b1;
  end

  always_comb begin
    case (rdAddr)
      ADDR_SEL:    rdData = selReg;
      ADDR_DC:     rdData = dcReg;
      ADDR_STATUS: rdData = {4'b0, invalidReg, abortReg, doneSync, initSync};
      default:     rdData = '0;
    endcase
  end

  AST_BOARD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(boardSel) || (&boardSel)); // R2
  AST_FPGA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fpgaSel) || (&fpgaSel)); // R3
  AST_INVALID_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.selInvalid |=> !resetStrobe); // R4
  AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resetStrobe |=> !resetStrobe); // R5
  AST_CLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.dcWr |=> $stable(clkLevel)); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clkRise && (pulseCount != COUNT_MAX)) |=> pulseCount == $past(pulseCount) + 1'b1); // R7
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.selWr |=> pulseCount == '0); // R7
  AST_ABORT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (abortReg && !strobes.selWr) |=> abortReg); // R9
endmodule

// File: rtl/cfg_serial_master.sv
module cfg_serial_master
  import cfg_pkg::*;
#(
  parameter int NUM_BOARDS  = 9,
  parameter int COUNT_W     = 18,
  parameter int SYNC_STAGES = 2,
  localparam int NUM_FPGAS  = REG_W - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wrEn,
  input  logic [1:0]            wrAddr,
  input  logic [REG_W-1:0]      wrData,
  input  logic [1:0]            rdAddr,
  output logic [REG_W-1:0]      rdData,
  output logic                  cfgClk,
  output logic [NUM_FPGAS-1:0]  cfgData,
  output logic [NUM_BOARDS-1:0] boardSel,
  output logic [NUM_FPGAS-1:0]  fpgaSel,
  output logic                  fpgaResetStrobe,
  input  logic                  initIn,
  input  logic                  doneIn,
  output logic [COUNT_W-1:0]    pulseCount
);
  cfgStrobe_t strobes;
  logic clkLevel;

  cfg_ctrl #(.NUM_BOARDS(NUM_BOARDS), .NUM_FPGAS(NUM_FPGAS)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clkLevel(clkLevel), .strobes(strobes)
  );

  cfg_datapath #(
    .NUM_BOARDS(NUM_BOARDS), .NUM_FPGAS(NUM_FPGAS),
    .COUNT_W(COUNT_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .clkLevel(clkLevel),
    .cfgData(cfgData), .boardSel(boardSel), .fpgaSel(fpgaSel),
    .resetStrobe(fpgaResetStrobe), .initIn(initIn), .doneIn(doneIn),
    .pulseCount(pulseCount)
  );

  assign cfgClk = clkLevel;
endmodule

// File: tb/cfg_serial_master_tb.sv
`timescale 1ns/1ps
module cfg_serial_master_tb;
  localparam int CW = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0, rdData;
  logic cfgClk, fpgaResetStrobe;
  logic [6:0] cfgData, fpgaSel;
  logic [8:0] boardSel;
  logic initIn = 1'b1, doneIn = 1'b0;
  logic [CW-1:0] pulseCount;
  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  cfg_serial_master #(.NUM_BOARDS(9), .COUNT_W(CW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cfgClk(cfgClk), .cfgData(cfgData),
    .boardSel(boardSel), .fpgaSel(fpgaSel), .fpgaResetStrobe(fpgaResetStrobe),
    .initIn(initIn), .doneIn(doneIn), .pulseCount(pulseCount)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic status(input int exp, input string tag);
    rdAddr = 2'd2; #0.1; chk(tag, rdData, exp);
  endtask

  task automatic pulse();
    wr(2'd1, 8'h00); wr(2'd1, 8'h80);
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 cfgClk", cfgClk, 0);
    chk("R1 cfgData", cfgData, 0);
    chk("R1 boardSel", boardSel, 0);
    chk("R1 fpgaSel", fpgaSel, 0);
    chk("R1 strobe", fpgaResetStrobe, 0);
    chk("R1 count", pulseCount, 0);
    status(0, "R1 status");
    rst_n = 1'b1;

    // R2 R3 R4 R5 sweep of every selection code
    for (int s = 0; s < 256; s++) begin
      int bf, ff, eb, ef, st;
      bit inv;
      bf = s & 15; ff = s >> 4;
      inv = (ff >= 8 && ff <= 13) || (bf >= 10 && bf <= 14);
      eb = inv ? 0 : (bf == 15) ? 'h1FF : (bf >= 1 && bf <= 9) ? (1 << (bf - 1)) : 0;
      ef = inv ? 0 : (ff == 15) ? 'h7F : (ff >= 1 && ff <= 7) ? (1 << (ff - 1)) : 0;
      st = (!inv && ff == 14 && bf != 0) ? 1 : 0;
      wr(2'd0, 8'(s));
      chk("R2 boardSel", boardSel, eb);
      chk("R3 fpgaSel", fpgaSel, ef);
      chk("R5 resetStrobe", fpgaResetStrobe, st);
      rdAddr = 2'd2; #0.1;
      chk("R4 invalid bit", (rdData >> 3) & 1, inv ? 1 : 0);
      rdAddr = 2'd0; #0.1;
      chk("R10 sel readback", rdData, s);
    end
    // R5 strobe lasts one cycle
    wr(2'd0, 8'hE3);
    chk("R5 strobe high", fpgaResetStrobe, 1);
    @(negedge clk);
    chk("R5 strobe single", fpgaResetStrobe, 0);
    chk("R5 board target", boardSel, 9'h004);
    chk("R5 no fpga", fpgaSel, 0);

    // R6 data lanes and clock
    wr(2'd0, 8'hF3);
    wr(2'd1, 8'h55);
    chk("R6 data all", cfgData, 7'h55);
    chk("R6 clk low", cfgClk, 0);
    wr(2'd0, 8'h21);
    wr(2'd1, 8'hFF);
    chk("R6 data masked", cfgData, 7'h02);
    chk("R6 clk high", cfgClk, 1);
    rdAddr = 2'd1; #0.1; chk("R10 dc readback", rdData, 8'hFF);
    rdAddr = 2'd3; #0.1; chk("R10 addr3 zero", rdData, 0);
    wr(2'd3, 8'h77);
    rdAddr = 2'd0; #0.1; chk("R10 ignored write", rdData, 8'h21);

    // R7 pulse counter
    wr(2'd0, 8'hF1);
    chk("R7 cleared", pulseCount, 0);
    for (int i = 0; i < 5; i++) pulse();
    chk("R7 five pulses", pulseCount, 5);
    wr(2'd1, 8'h80);
    chk("R7 no edge", pulseCount, 5);
    for (int i = 0; i < 12; i++) pulse();
    chk("R7 saturate", pulseCount, 15);
    wr(2'd0, 8'hF1);
    chk("R7 clear on select", pulseCount, 0);

    // R8 R9 synchronizer and abort
    repeat (3) @(negedge clk);
    status(1, "R8 init high");
    initIn = 1'b0;
    repeat (4) @(negedge clk);
    status(0, "R9 no abort at zero count");
    initIn = 1'b1;
    repeat (3) @(negedge clk);
    pulse();
    initIn = 1'b0;
    @(negedge clk); status(1, "R8 one edge");
    @(negedge clk); status(0, "R8 two edges");
    @(negedge clk); status(4, "R9 abort set");
    initIn = 1'b1;
    repeat (4) @(negedge clk);
    status(5, "R9 abort sticky");
    doneIn = 1'b1;
    repeat (3) @(negedge clk);
    status(7, "R8 done");
    wr(2'd0, 8'hF1);
    status(3, "R9 abort cleared");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule